// File: doc/BRIEF.md
# Time-Slot Parity Unit

This block watches two serial PCM bit streams, one per direction, and attaches a parity bit to every 8-bit time slot. Each stream carries one bit per qualified clock, with the most significant bit first. A strobe marks the eighth (least significant) bit of each slot. When a slot closes, the parity of that slot appears on the slot's parity output and stays there for the whole of the following slot.

On the receive side the parity is taken over the data as it enters the speech store. A control input sets whether the output is even or odd. On the transmit side the parity is either computed internally as even parity over the slot data, or copied from an external per-slot parity pin. That pin is sampled together with the eighth bit and has its own inversion control. In 30-channel mode only the external source has meaning, so the internal generator is overridden. Also in 30-channel mode, a running even parity is built over all receive bits of a doubleframe. It is published on a dedicated output at each doubleframe start.

Top module: `slot_parity_unit`

## Requirements
- R1: While reset is asserted and after its release until the first slot closes, `rx_par`, `tx_par` and `dfrm_par` are 0.
- R2: One clock after the qualified bit marked by `slot_last`, `rx_par` equals the XOR of the slot's 8 `rx_data` bits XOR `rx_par_odd` (0 = even, 1 = odd). Slots are exactly 8 qualified bits long.
- R3: `rx_par` and `tx_par` change only in the clock after a qualified `slot_last` bit. They hold their value through every bit of the following slot.
- R4: With `mode30`=0 and `tx_ext_sel`=0, `tx_par` equals the even parity (XOR) of the slot's 8 `tx_data` bits.
- R5: With `tx_ext_sel`=1, `tx_par` equals `tx_ext_par` XOR `tx_ext_inv`, both sampled on the `slot_last` bit. The value of `tx_ext_par` on the other seven bits has no effect.
- R6: With `mode30`=1, `tx_par` follows the external source as in R5 whatever `tx_ext_sel` is.
- R7: With `mode30`=1, one clock after a qualified bit with `dfrm_start`=1, `dfrm_par` equals the XOR of all `rx_data` bits from the previous doubleframe start up to the bit before this one. It then holds until the next doubleframe start.
- R8: With `mode30`=0, `dfrm_par` is 0 from the next clock on.
- R9: Cycles with `bit_en`=0 have no effect. Data, strobes and the external parity pin are ignored in those cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Qualifies one serial bit in this cycle |
| slot_last | input | 1 | Current bit is bit 8 (LSB) of its slot |
| dfrm_start | input | 1 | Current bit is the first bit of a doubleframe |
| mode30 | input | 1 | 1 = 30-channel mode, 0 = 24-channel mode |
| rx_data | input | 1 | Receive serial data into the speech store |
| rx_par_odd | input | 1 | Receive parity output sense |
| tx_data | input | 1 | Transmit serial data |
| tx_ext_sel | input | 1 | 1 = transmit parity from external pin |
| tx_ext_par | input | 1 | External transmit parity, valid with bit 8 |
| tx_ext_inv | input | 1 | Inverts the external transmit parity |
| rx_par | output | 1 | Receive slot parity, held for the next slot |
| tx_par | output | 1 | Transmit slot parity, held for the next slot |
| dfrm_par | output | 1 | Doubleframe even parity (30-channel mode) |

## Verification
Each result sits one register behind its stimulus. Slot parities update on the clock edge that samples the `slot_last` bit. The doubleframe parity updates on the edge that samples the `dfrm_start` bit. Mode-off clearing shows one edge after `mode30` falls. The bench drives inputs on the falling edge and closes each slot with one idle cycle. It then reads the outputs on the next falling edge, exactly one rising edge after the closing bit. The hold checks sample after every intermediate bit of the following slot.

// File: rtl/slot_par_pkg.sv
package slot_par_pkg;
  localparam int SLOT_BITS = 8;
  localparam int CNT_W     = $clog2(SLOT_BITS);

  typedef enum logic {
    SRC_INTERNAL = 1'b0,
    SRC_EXTERNAL = 1'b1
  } tx_src_e;
endpackage

// File: rtl/slot_par_acc.sv
module slot_par_acc
  import slot_par_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    bit_en,
  input  logic    slot_end,
  input  logic    din,
  input  logic    sense,
  input  tx_src_e src,
  input  logic    ext_bit,
  output logic    par_o
);
  logic             acc_q, acc_d;
  logic             par_q, par_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    acc_d = acc_q;
    par_d = par_q;
    cnt_d = cnt_q;
    if (slot_end) begin
      acc_d = 1'b0;
      cnt_d = '0;
      if (src == SRC_EXTERNAL) par_d = ext_bit;
      else                     par_d = acc_q ^ din ^ sense;
    end else begin
      acc_d = acc_q ^ din;
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= 1'b0;
      par_q <= 1'b0;
      cnt_q <= '0;
    end else if (bit_en) begin
      acc_q <= acc_d;
      par_q <= par_d;
      cnt_q <= cnt_d;
    end
  end

  assign par_o = par_q;

  // R3
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_en && slot_end) |=> $stable(par_o));

  // R2
  slot_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && slot_end) |-> (cnt_q == CNT_W'(SLOT_BITS - 1)));
endmodule

// File: rtl/dfrm_par_acc.sv
module dfrm_par_acc (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic enable,
  input  logic dfrm_start,
  input  logic din,
  output logic par_o
);
  logic acc_q, acc_d;
  logic res_q, res_d;
  logic upd;

  assign upd = bit_en || !enable;

  always_comb begin
    acc_d = acc_q;
    res_d = res_q;
    if (!enable) begin
      acc_d = 1'b0;
      res_d = 1'b0;
    end else if (dfrm_start) begin
      res_d = acc_q;
      acc_d = din;
    end else begin
      acc_d = acc_q ^ din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= 1'b0;
      res_q <= 1'b0;
    end else if (upd) begin
      acc_q <= acc_d;
      res_q <= res_d;
    end
  end

  assign par_o = res_q;

  // R8
  dfrm_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !par_o);

  // R7
  dfrm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !(bit_en && dfrm_start)) |=> $stable(par_o));
endmodule

// File: rtl/slot_parity_unit.sv
module slot_parity_unit
  import slot_par_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic slot_last,
  input  logic dfrm_start,
  input  logic mode30,
  input  logic rx_data,
  input  logic rx_par_odd,
  input  logic tx_data,
  input  logic tx_ext_sel,
  input  logic tx_ext_par,
  input  logic tx_ext_inv,
  output logic rx_par,
  output logic tx_par,
  output logic dfrm_par
);
  tx_src_e tx_src;
  logic    tx_ext_bit;

  always_comb begin
    if (mode30 || tx_ext_sel) tx_src = SRC_EXTERNAL;
    else                      tx_src = SRC_INTERNAL;
  end

  assign tx_ext_bit = tx_ext_par ^ tx_ext_inv;

  slot_par_acc u_rx_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .slot_end (slot_last),
    .din      (rx_data),
    .sense    (rx_par_odd),
    .src      (SRC_INTERNAL),
    .ext_bit  (1'b0),
    .par_o    (rx_par)
  );

  slot_par_acc u_tx_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .slot_end (slot_last),
    .din      (tx_data),
    .sense    (1'b0),
    .src      (tx_src),
    .ext_bit  (tx_ext_bit),
    .par_o    (tx_par)
  );

  dfrm_par_acc u_dfrm (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .enable     (mode30),
    .dfrm_start (dfrm_start),
    .din        (rx_data),
    .par_o      (dfrm_par)
  );

  // R6
  tx_mode30_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode30 && bit_en && slot_last) |=> (tx_par == $past(tx_ext_par ^ tx_ext_inv)));

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    !rst_n |-> (!rx_par && !tx_par && !dfrm_par));
endmodule

// File: tb/slot_parity_unit_test.sv
module slot_parity_unit_test;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n;
  logic bit_en, slot_last, dfrm_start, mode30;
  logic rx_data, rx_par_odd, tx_data, tx_ext_sel, tx_ext_par, tx_ext_inv;
  logic rx_par, tx_par, dfrm_par;

  int nchk = 0;
  int nerr = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  slot_parity_unit uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .slot_last(slot_last),
    .dfrm_start(dfrm_start), .mode30(mode30), .rx_data(rx_data),
    .rx_par_odd(rx_par_odd), .tx_data(tx_data), .tx_ext_sel(tx_ext_sel),
    .tx_ext_par(tx_ext_par), .tx_ext_inv(tx_ext_inv), .rx_par(rx_par),
    .tx_par(tx_par), .dfrm_par(dfrm_par)
  );

  task automatic check(input string req, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic bit_cycle(input logic rb, input logic tb, input logic last,
                           input logic dfs, input logic ext);
    @(negedge clk);
    bit_en = 1'b1; rx_data = rb; tx_data = tb;
    slot_last = last; dfrm_start = dfs; tx_ext_par = ext;
  endtask

  task automatic gap(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      bit_en = 1'b0;
      rx_data = 1'($urandom); tx_data = 1'($urandom);
      slot_last = 1'($urandom); dfrm_start = 1'($urandom);
      tx_ext_par = 1'($urandom);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    bit_en = 1'b0; slot_last = 1'b0; dfrm_start = 1'b0;
  endtask

  task automatic send_slot(input logic [7:0] rb, input logic [7:0] tb,
                           input logic ext, input logic dfs, input int gaps);
    for (int i = 7; i >= 0; i--) begin
      bit_cycle(rb[i], tb[i], i == 0, dfs && (i == 7), (i == 0) ? ext : ~ext);
      if (gaps > 0 && i != 0) gap(gaps);
    end
    settle();
  endtask

  task automatic t_reset();
    check("R1 rx_par after reset", rx_par, 1'b0);
    check("R1 tx_par after reset", tx_par, 1'b0);
    check("R1 dfrm_par after reset", dfrm_par, 1'b0);
  endtask

  task automatic t_rx_parity();
    rx_par_odd = 1'b0;
    send_slot(8'hA5, 8'h00, 1'b0, 1'b0, 0); check("R2 rx A5 even", rx_par, 1'b0);
    send_slot(8'h01, 8'h00, 1'b0, 1'b0, 0); check("R2 rx 01 even", rx_par, 1'b1);
    send_slot(8'hFF, 8'h00, 1'b0, 1'b0, 0); check("R2 rx FF even", rx_par, 1'b0);
    rx_par_odd = 1'b1;
    send_slot(8'h07, 8'h00, 1'b0, 1'b0, 0); check("R2 rx 07 odd", rx_par, 1'b0);
    send_slot(8'h00, 8'h00, 1'b0, 1'b0, 0); check("R2 rx 00 odd", rx_par, 1'b1);
    rx_par_odd = 1'b0;
  endtask

  task automatic t_hold();
    send_slot(8'h01, 8'h01, 1'b0, 1'b0, 0);
    for (int i = 7; i >= 1; i--) begin
      bit_cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      settle();
      check("R3 rx_par held mid-slot", rx_par, 1'b1);
      check("R3 tx_par held mid-slot", tx_par, 1'b1);
    end
    bit_cycle(1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    settle();
    check("R3 rx_par updates at slot end", rx_par, 1'b0);
  endtask

  task automatic t_tx_int();
    mode30 = 1'b0; tx_ext_sel = 1'b0; tx_ext_inv = 1'b0;
    send_slot(8'h00, 8'h03, 1'b1, 1'b0, 0); check("R4 tx internal 03", tx_par, 1'b0);
    send_slot(8'h00, 8'h0B, 1'b0, 1'b0, 0); check("R4 tx internal 0B", tx_par, 1'b1);
  endtask

  task automatic t_tx_ext();
    mode30 = 1'b0; tx_ext_sel = 1'b1; tx_ext_inv = 1'b0;
    send_slot(8'h00, 8'h00, 1'b1, 1'b0, 0); check("R5 tx external plain", tx_par, 1'b1);
    send_slot(8'h00, 8'h01, 1'b0, 1'b0, 0); check("R5 tx external plain 0", tx_par, 1'b0);
    tx_ext_inv = 1'b1;
    send_slot(8'h00, 8'h00, 1'b1, 1'b0, 0); check("R5 tx external inverted", tx_par, 1'b0);
    tx_ext_inv = 1'b0; tx_ext_sel = 1'b0;
  endtask

  task automatic t_mode30_tx();
    mode30 = 1'b1; tx_ext_sel = 1'b0; tx_ext_inv = 1'b0;
    send_slot(8'h00, 8'h01, 1'b0, 1'b0, 0); check("R6 mode30 forces external 0", tx_par, 1'b0);
    send_slot(8'h00, 8'h00, 1'b1, 1'b0, 0); check("R6 mode30 forces external 1", tx_par, 1'b1);
  endtask

  task automatic t_dfrm();
    mode30 = 1'b1;
    send_slot(8'h01, 8'h00, 1'b0, 1'b1, 0);
    send_slot(8'h03, 8'h00, 1'b0, 1'b0, 0);
    send_slot(8'h07, 8'h00, 1'b0, 1'b0, 0);
    send_slot(8'h80, 8'h00, 1'b0, 1'b1, 0);
    check("R7 doubleframe six ones", dfrm_par, 1'b0);
    send_slot(8'h03, 8'h00, 1'b0, 1'b0, 0);
    check("R7 doubleframe held", dfrm_par, 1'b0);
    send_slot(8'h00, 8'h00, 1'b0, 1'b1, 0);
    check("R7 doubleframe three ones", dfrm_par, 1'b1);
    send_slot(8'hFF, 8'h00, 1'b0, 1'b0, 0);
    check("R7 doubleframe held over slot", dfrm_par, 1'b1);
    mode30 = 1'b0;
    settle();
    check("R8 doubleframe off in 24-ch mode", dfrm_par, 1'b0);
    send_slot(8'h00, 8'h00, 1'b0, 1'b1, 0);
    check("R8 doubleframe stays 0", dfrm_par, 1'b0);
  endtask

  task automatic t_gaps();
    mode30 = 1'b0; tx_ext_sel = 1'b0; rx_par_odd = 1'b0;
    send_slot(8'h0F, 8'h01, 1'b0, 1'b0, 2);
    check("R9 rx ignores idle cycles", rx_par, 1'b0);
    check("R9 tx ignores idle cycles", tx_par, 1'b1);
    send_slot(8'h1F, 8'h00, 1'b0, 1'b0, 3);
    check("R9 rx ignores idle cycles odd", rx_par, 1'b1);
    gap(4);
    settle();
    check("R9 rx unchanged by idle strobes", rx_par, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; bit_en = 1'b0; slot_last = 1'b0; dfrm_start = 1'b0;
    mode30 = 1'b0; rx_data = 1'b0; rx_par_odd = 1'b0; tx_data = 1'b0;
    tx_ext_sel = 1'b0; tx_ext_par = 1'b0; tx_ext_inv = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    settle();
    t_reset();
    t_rx_parity();
    t_hold();
    t_tx_int();
    t_tx_ext();
    t_mode30_tx();
    t_dfrm();
    t_gaps();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule